// File: doc/BRIEF.md
# Program Counter with Next-Address Selection

This block holds the instruction address of a small 16-bit processor whose instructions are two bytes wide. The address is 8 bits. On each rising clock edge the block picks one of four next values and loads it into its register: the sequential address (current plus two), a relative branch target, an absolute jump target, or the current address again when the processor has stopped.

Decode and the ALU sit outside the block. They supply a branch flag, the ALU zero flag, a jump flag, a halt flag, a 4-bit signed branch displacement counted in instructions, and a 12-bit unsigned jump field counted in instructions. The output is the current address, which drives the instruction memory. A halt request is sticky. The address then stays frozen until the next reset.

Top module: `pc_seq_unit`

## Requirements
- R1: When `rst` is high at a rising edge, `pc` becomes 0x00 and any stopped state is cleared.
- R2: If the block is not stopped, `halt_req` and `jmp_en` are low, and the branch is not taken, `pc` advances by 2 at each rising edge.
- R3: If `br_en` and `alu_zero` are both 1, the next `pc` is old `pc` + 2 + 2 × `br_ofs`. Here `br_ofs` is two's complement, so 0xC means −4. From 0x0C, a displacement of 0xC gives 0x06. From 0x06, a displacement of 0x5 gives 0x12. From 0x12, a displacement of 0x2 gives 0x18.
- R4: If only one of `br_en` and `alu_zero` is 1, the branch is not taken and `pc` advances by 2.
- R5: If `jmp_en` is 1, the next `pc` is 2 × `jmp_fld`, treated as unsigned. Only the low 8 bits of the doubled value are kept, so `pc` bit 0 stays 0.
- R6: Priority is halt first, then jump, then a taken branch, then sequential flow. A halt request at an edge keeps `pc` unchanged at that edge. A jump overrides a taken branch.
- R7: After `halt_req` has been seen at an edge, `pc` holds its value at every later edge, whatever the other inputs do, until `rst` is applied.
- R8: All address arithmetic wraps modulo 256. From 0xFE, sequential flow gives 0x00. From 0x00, a taken branch with displacement 0x8 gives 0xF2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| br_en | input | 1 | Current instruction is a conditional branch |
| alu_zero | input | 1 | ALU reports equal operands |
| jmp_en | input | 1 | Current instruction is an absolute jump |
| halt_req | input | 1 | Stop fetching; sticky until reset |
| br_ofs | input | 4 | Signed branch displacement in instructions |
| jmp_fld | input | 12 | Unsigned jump target in instructions |
| pc | output | 8 | Current instruction address |

## Verification
The properties assume that `rst` is asserted at the first clock edge. They also assume that every control input is a known 0 or 1 at each sampled edge, because the reference values are taken with `$past` from the edge before. The bench drives every input at the falling edge. It holds `rst` high from time zero through the first rising edges. It never leaves a flag undriven. Flag combinations that decode would never produce, such as jump and branch together, are applied on purpose to exercise the priority order.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  typedef enum logic [1:0] {
    SEL_SEQ  = 2'd0,
    SEL_BR   = 2'd1,
    SEL_JMP  = 2'd2,
    SEL_HOLD = 2'd3
  } nxt_sel_e;

endpackage

// File: rtl/pcu_target.sv
module pcu_target #(
  parameter int PC_W  = 8,
  parameter int OFS_W = 4,
  parameter int JF_W  = 12
) (
  input  logic [PC_W-1:0]  cur_pc,
  input  logic [OFS_W-1:0] ofs,
  input  logic [JF_W-1:0]  jfld,
  output logic [PC_W-1:0]  seq_addr,
  output logic [PC_W-1:0]  br_addr,
  output logic [PC_W-1:0]  jmp_addr
);

  localparam int STEP   = 2;
  localparam int WIDE_W = PC_W + JF_W + 1;

  function automatic logic [PC_W-1:0] f_seq(input logic [PC_W-1:0] a);
    return a + PC_W'(STEP);
  endfunction

  function automatic logic [PC_W-1:0] f_branch(input logic [PC_W-1:0] a,
                                               input logic [OFS_W-1:0] d);
    logic [PC_W-1:0] ext;
    ext = PC_W'($signed(d));
    return f_seq(a) + (ext << 1);
  endfunction

  function automatic logic [PC_W-1:0] f_jump(input logic [JF_W-1:0] f);
    logic [WIDE_W-1:0] wide;
    wide = {{PC_W{1'b0}}, f, 1'b0};
    return wide[PC_W-1:0];
  endfunction

  assign seq_addr = f_seq(cur_pc);
  assign br_addr  = f_branch(cur_pc, ofs);
  assign jmp_addr = f_jump(jfld);

endmodule

// File: rtl/pcu_select.sv
module pcu_select
  import pcu_pkg::*;
(
  input  logic     br_en,
  input  logic     alu_zero,
  input  logic     jmp_en,
  input  logic     halt_req,
  input  logic     halted,
  output logic     br_taken,
  output nxt_sel_e sel
);

  always_comb begin
    br_taken = br_en & alu_zero;
    if (halted | halt_req)  sel = SEL_HOLD;
    else if (jmp_en)        sel = SEL_JMP;
    else if (br_taken)      sel = SEL_BR;
    else                    sel = SEL_SEQ;
  end

endmodule

// File: rtl/pcu_state.sv
module pcu_state
  import pcu_pkg::*;
#(
  parameter int PC_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  nxt_sel_e        sel,
  input  logic            halt_req,
  input  logic [PC_W-1:0] seq_addr,
  input  logic [PC_W-1:0] br_addr,
  input  logic [PC_W-1:0] jmp_addr,
  output logic [PC_W-1:0] pc_q,
  output logic            halted
);

  logic [PC_W-1:0] pc_d;

  always_comb begin
    unique case (sel)
      SEL_SEQ:  pc_d = seq_addr;
      SEL_BR:   pc_d = br_addr;
      SEL_JMP:  pc_d = jmp_addr;
      default:  pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      halted <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      halted <= halted | halt_req;
    end
  end

endmodule

// File: rtl/pc_seq_unit.sv
module pc_seq_unit
  import pcu_pkg::*;
#(
  parameter int PC_W  = 8,
  parameter int OFS_W = 4,
  parameter int JF_W  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             br_en,
  input  logic             alu_zero,
  input  logic             jmp_en,
  input  logic             halt_req,
  input  logic [OFS_W-1:0] br_ofs,
  input  logic [JF_W-1:0]  jmp_fld,
  output logic [PC_W-1:0]  pc
);

  logic [PC_W-1:0] seq_addr, br_addr, jmp_addr;
  logic            halted, br_taken;
  nxt_sel_e        sel;

  pcu_target #(.PC_W(PC_W), .OFS_W(OFS_W), .JF_W(JF_W)) u_target (
    .cur_pc(pc), .ofs(br_ofs), .jfld(jmp_fld),
    .seq_addr(seq_addr), .br_addr(br_addr), .jmp_addr(jmp_addr)
  );

  pcu_select u_select (
    .br_en(br_en), .alu_zero(alu_zero), .jmp_en(jmp_en),
    .halt_req(halt_req), .halted(halted),
    .br_taken(br_taken), .sel(sel)
  );

  pcu_state #(.PC_W(PC_W)) u_state (
    .clk(clk), .rst(rst), .sel(sel), .halt_req(halt_req),
    .seq_addr(seq_addr), .br_addr(br_addr), .jmp_addr(jmp_addr),
    .pc_q(pc), .halted(halted)
  );

  // R1: reset clears the address
  p_reset_zero_r1: assert property (@(posedge clk) rst |=> pc == '0);

  // R2 and R4: plain advance by two
  p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!halted && !halt_req && !jmp_en && !(br_en && alu_zero))
      |=> pc == PC_W'($past(pc) + PC_W'(2)));

  // R3: taken branch relative to the sequential address
  p_branch_r3: assert property (@(posedge clk) disable iff (rst)
    (!halted && !halt_req && !jmp_en && br_en && alu_zero)
      |=> pc == PC_W'($past(pc) + PC_W'(2) + PC_W'({PC_W'($signed($past(br_ofs))), 1'b0})));

  // R5: jump target stays even
  p_jump_even_r5: assert property (@(posedge clk) disable iff (rst)
    (!halted && !halt_req && jmp_en) |=> pc[0] == 1'b0);

  // R6: a halt request freezes the address at that edge
  p_halt_now_r6: assert property (@(posedge clk) disable iff (rst)
    halt_req |=> $stable(pc));

  // R7: once stopped, stays frozen
  p_halt_hold_r7: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(pc) && halted);

endmodule

// File: tb/tb_pc_seq_unit.sv
`timescale 1ns/1ps
module tb_pc_seq_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        br_en = 1'b0, alu_zero = 1'b0, jmp_en = 1'b0, halt_req = 1'b0;
  logic [3:0]  br_ofs = '0;
  logic [11:0] jmp_fld = '0;
  logic [7:0]  pc;

  int checks = 0;
  int errors = 0;
  int    exp_q[$];
  string tag_q[$];
  int    m_pc = 0;
  bit    m_halt = 1'b0;
  bit    finished = 1'b0;

  always #10 clk = ~clk;

  pc_seq_unit dut (
    .clk(clk), .rst(rst), .br_en(br_en), .alu_zero(alu_zero),
    .jmp_en(jmp_en), .halt_req(halt_req), .br_ofs(br_ofs),
    .jmp_fld(jmp_fld), .pc(pc)
  );

  // driver: applies one cycle of stimulus and pushes the expected address
  task automatic drive(input bit r, input bit b, input bit z, input bit j,
                       input bit h, input logic [3:0] o, input logic [11:0] f,
                       input string tag);
    int so;
    rst = r; br_en = b; alu_zero = z; jmp_en = j; halt_req = h;
    br_ofs = o; jmp_fld = f;
    so = o[3] ? int'(o) - 16 : int'(o);
    if (r) begin
      m_pc = 0; m_halt = 1'b0;
    end else if (m_halt || h) begin
      m_halt = 1'b1;
    end else if (j) begin
      m_pc = (int'(f) * 2) % 256;
    end else if (b && z) begin
      m_pc = (((m_pc + 2 + 2 * so) % 256) + 256) % 256;
    end else begin
      m_pc = (m_pc + 2) % 256;
    end
    exp_q.push_back(m_pc);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  // monitor: compares just after each edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      int    e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (int'(pc) != e) begin
        errors++;
        $display("FAIL %s: pc actual 0x%02h expected 0x%02h", t, pc, e[7:0]);
      end
    end
  end

  initial begin
    #(20ns * 5000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    drive(1, 0, 0, 0, 0, 4'h0, 12'h000, "R1 reset");
    drive(1, 1, 1, 1, 0, 4'h3, 12'h055, "R1 reset beats flags");
    for (int i = 0; i < 6; i++) drive(0, 0, 0, 0, 0, 4'h0, 12'h000, "R2 sequential");
    drive(0, 1, 1, 0, 0, 4'hC, 12'h000, "R3 branch -4 from 0C");
    drive(0, 1, 1, 0, 0, 4'h5, 12'h000, "R3 branch +5 from 06");
    drive(0, 1, 1, 0, 0, 4'h2, 12'h000, "R3 branch +2 from 12");
    drive(0, 1, 0, 0, 0, 4'h7, 12'h000, "R4 branch flag only");
    drive(0, 0, 1, 0, 0, 4'h7, 12'h000, "R4 zero flag only");
    drive(0, 0, 0, 1, 0, 4'h0, 12'h003, "R5 jump to 06");
    drive(0, 0, 0, 1, 0, 4'h0, 12'hFFF, "R5 R8 jump field truncated");
    drive(0, 0, 0, 0, 0, 4'h0, 12'h000, "R8 wrap FE to 00");
    drive(0, 1, 1, 0, 0, 4'h8, 12'h000, "R8 branch -8 from 00");
    drive(0, 1, 1, 0, 0, 4'hF, 12'h000, "R3 branch -1 self loop");
    drive(0, 1, 1, 1, 0, 4'h3, 12'h020, "R6 jump over branch");
    drive(0, 0, 0, 0, 0, 4'h0, 12'h000, "R2 sequential after jump");
    drive(0, 1, 1, 1, 1, 4'h3, 12'h011, "R6 halt over jump");
    drive(0, 0, 0, 0, 0, 4'h0, 12'h000, "R7 hold sequential");
    drive(0, 0, 0, 1, 0, 4'h0, 12'h033, "R7 hold jump");
    drive(0, 1, 1, 0, 0, 4'h4, 12'h000, "R7 hold branch");
    drive(1, 0, 0, 0, 0, 4'h0, 12'h000, "R1 reset clears halt");
    drive(0, 0, 0, 0, 0, 4'h0, 12'h000, "R2 runs after reset");
    drive(0, 0, 0, 0, 0, 4'h0, 12'h000, "R2 runs after reset");
    drive(0, 0, 0, 0, 0, 4'h0, 12'h000, "R2 settle");
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule